// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block moves data between two buses, A and B, of a parameterized width (18 bits by default). Each direction has its own storage path that runs in one of three ways: transparent, where the opposite bus follows the input bus; clocked, where the input bus is stored on a rising edge of that direction's data strobe while the strobe enable is low; and held, where the stored word stays on the output. The A-to-B and B-to-A paths are identical and fully independent. Each path is controlled by a pass (transparent) select, a data strobe, an active-low strobe enable and an active-low drive enable.

The tri-state pins are modelled for synthesis as a data output and a drive flag per bus. A pad wrapper turns each pair into a real three-state driver. The strobes, enables and buses are sampled on the block clock `clk`. A strobe rising edge is a sample where the strobe is high and the sample before it was low. Reset is synchronous and active high.

Top module: `bus_xcvr`

## Requirements
- R1: While a direction's pass select is 1, its output equals its input bus in the same cycle, whatever the strobe and strobe enable are doing.
- R2: While pass is 0 and the strobe enable is 0, a strobe rising edge (1 at a clock sample, 0 at the sample before) stores the input bus present at that sample. The stored word appears on the output after that clock edge.
- R3: While pass is 0 and the strobe stays 0, the output holds its stored word.
- R4: While pass is 0 and the strobe was already 1 before pass went to 0 and stays 1, the output holds its stored word (no capture).
- R5: While pass is 0 and the strobe enable is 1, strobe edges are ignored and the stored word is held.
- R6: Outside reset, the drive flag of the bus a direction feeds is 1 when its drive enable is 0, and 0 when its drive enable is 1, regardless of every other input.
- R7: The A-to-B path (pass, strobe, enable and drive for A-to-B; input on the A bus; output on the B bus) and the B-to-A path (its own four controls; input on the B bus; output on the A bus) never influence each other.
- R8: Reset clears both stored words to zero and holds both drive flags at 0. The strobe history resets to 1, so a strobe already high when reset ends does not capture.
- R9: If pass falls while the strobe is 0, a later strobe rising edge with the enable at 0 captures.
- R10: Storage keeps updating, through pass and through captures, while the drive flag is 0. The updated word shows once drive is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all controls are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | W | A bus value seen at the pads |
| a_out | output | W | Data the B-to-A path drives onto the A bus |
| a_drv | output | 1 | 1 when the A bus pads are driven |
| b_in | input | W | B bus value seen at the pads |
| b_out | output | W | Data the A-to-B path drives onto the B bus |
| b_drv | output | 1 | 1 when the B bus pads are driven |
| ab_pass | input | 1 | A-to-B transparent select, 1 = follow A |
| ab_strobe | input | 1 | A-to-B data strobe, stores on rising edge |
| ab_strobe_en_n | input | 1 | A-to-B strobe enable, active low |
| ab_drive_n | input | 1 | B bus drive enable, active low |
| ba_pass | input | 1 | B-to-A transparent select, 1 = follow B |
| ba_strobe | input | 1 | B-to-A data strobe, stores on rising edge |
| ba_strobe_en_n | input | 1 | B-to-A strobe enable, active low |
| ba_drive_n | input | 1 | A bus drive enable, active low |

## Verification
The assertions assume every control and bus input is synchronous to `clk`. Each input changes at most once per clock period and settles before the next rising edge. A strobe level therefore has to last at least one clock period to be seen, and a pass transition is judged against the bus value at the same sample. The bench changes every input just after the falling edge of `clk` and observes shortly after. Random control sequences are applied to one direction at a time while the other stays fixed, which keeps R7 observable.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int DIRS   = 2;
    localparam int DIR_AB = 0;
    localparam int DIR_BA = 1;

    typedef enum logic [1:0] {
        MODE_PASS    = 2'd0,
        MODE_CAPTURE = 2'd1,
        MODE_HOLD    = 2'd2
    } store_mode_e;

    typedef struct packed {
        logic pass;
        logic strobe;
        logic strobe_en_n;
        logic drive_n;
    } dir_ctrl_t;

    // Transparency wins; a qualified strobe edge captures; otherwise hold.
    function automatic store_mode_e pick_mode(input dir_ctrl_t c, input logic rise);
        if (c.pass)
            return MODE_PASS;
        else if (rise && !c.strobe_en_n)
            return MODE_CAPTURE;
        else
            return MODE_HOLD;
    endfunction

endpackage

// File: rtl/xcvr_strobe_edge.sv
module xcvr_strobe_edge (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    output logic rise
);
    logic last_q;

    // History resets high: a strobe already high after reset is not an edge.
    always_ff @(posedge clk) begin
        if (rst)
            last_q <= 1'b1;
        else
            last_q <= strobe;
    end

    assign rise = strobe & ~last_q;
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store
    import xcvr_pkg::*;
#(
    parameter int W = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  store_mode_e   mode,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            unique case (mode)
                MODE_PASS,
                MODE_CAPTURE: q <= din;
                default:      q <= q;
            endcase
        end
    end
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
    import xcvr_pkg::*;
#(
    parameter int W = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  dir_ctrl_t     ctrl,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout,
    output logic          drv
);
    logic          rise;
    store_mode_e   mode;
    logic [W-1:0]  held;

    xcvr_strobe_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .strobe (ctrl.strobe),
        .rise   (rise)
    );

    assign mode = pick_mode(ctrl, rise);

    xcvr_store #(.W(W)) u_store (
        .clk  (clk),
        .rst  (rst),
        .mode (mode),
        .din  (din),
        .q    (held)
    );

    // Transparent path bypasses storage; drive gating never touches storage.
    assign dout = ctrl.pass ? din : held;
    assign drv  = ~ctrl.drive_n & ~rst;
endmodule

// File: rtl/bus_xcvr.sv
module bus_xcvr
    import xcvr_pkg::*;
#(
    parameter int W = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  a_in,
    output logic [W-1:0]  a_out,
    output logic          a_drv,
    input  logic [W-1:0]  b_in,
    output logic [W-1:0]  b_out,
    output logic          b_drv,
    input  logic          ab_pass,
    input  logic          ab_strobe,
    input  logic          ab_strobe_en_n,
    input  logic          ab_drive_n,
    input  logic          ba_pass,
    input  logic          ba_strobe,
    input  logic          ba_strobe_en_n,
    input  logic          ba_drive_n
);
    dir_ctrl_t     ctrl     [DIRS];
    logic [W-1:0]  lane_in  [DIRS];
    logic [W-1:0]  lane_out [DIRS];
    logic          lane_drv [DIRS];

    assign ctrl[DIR_AB] = '{pass: ab_pass, strobe: ab_strobe,
                            strobe_en_n: ab_strobe_en_n, drive_n: ab_drive_n};
    assign ctrl[DIR_BA] = '{pass: ba_pass, strobe: ba_strobe,
                            strobe_en_n: ba_strobe_en_n, drive_n: ba_drive_n};

    assign lane_in[DIR_AB] = a_in;
    assign lane_in[DIR_BA] = b_in;

    for (genvar g = 0; g < DIRS; g++) begin : g_lane
        xcvr_lane #(.W(W)) u_lane (
            .clk  (clk),
            .rst  (rst),
            .ctrl (ctrl[g]),
            .din  (lane_in[g]),
            .dout (lane_out[g]),
            .drv  (lane_drv[g])
        );
    end

    assign b_out = lane_out[DIR_AB];
    assign b_drv = lane_drv[DIR_AB];
    assign a_out = lane_out[DIR_BA];
    assign a_drv = lane_drv[DIR_BA];
endmodule

// File: rtl/xcvr_dir_chk.sv
module xcvr_dir_chk #(
    parameter int W = 18
) (
    input logic          clk,
    input logic          rst,
    input logic          pass,
    input logic          strobe,
    input logic          strobe_en_n,
    input logic          drive_n,
    input logic [W-1:0]  din,
    input logic [W-1:0]  dout,
    input logic          drv
);
    p_pass_follow_r1: assert property (@(posedge clk) disable iff (rst)
        pass |-> dout == din);

    p_capture_r2: assert property (@(posedge clk) disable iff (rst)
        (!pass && !strobe_en_n && strobe && !$past(strobe) && !$past(rst))
        |=> (pass || dout == $past(din)));

    p_hold_low_r3: assert property (@(posedge clk) disable iff (rst)
        (!pass && !strobe) |=> (pass || $stable(dout)));

    p_hold_high_r4: assert property (@(posedge clk) disable iff (rst)
        (!pass && strobe && $past(strobe)) |=> (pass || $stable(dout)));

    p_gate_off_r5: assert property (@(posedge clk) disable iff (rst)
        (!pass && strobe_en_n) |=> (pass || $stable(dout)));

    p_drive_off_r6: assert property (@(posedge clk) disable iff (rst)
        drive_n |-> !drv);

    p_drive_on_r6: assert property (@(posedge clk) disable iff (rst)
        !drive_n |-> drv);

    p_reset_word_r8: assert property (@(posedge clk) disable iff (rst)
        (!pass && $past(rst)) |-> dout == '0);

    p_reset_drv_r8: assert property (@(posedge clk)
        rst |-> !drv);
endmodule

bind bus_xcvr xcvr_dir_chk #(.W(W)) u_chk_ab (
    .clk(clk), .rst(rst), .pass(ab_pass), .strobe(ab_strobe),
    .strobe_en_n(ab_strobe_en_n), .drive_n(ab_drive_n),
    .din(a_in), .dout(b_out), .drv(b_drv)
);

bind bus_xcvr xcvr_dir_chk #(.W(W)) u_chk_ba (
    .clk(clk), .rst(rst), .pass(ba_pass), .strobe(ba_strobe),
    .strobe_en_n(ba_strobe_en_n), .drive_n(ba_drive_n),
    .din(b_in), .dout(a_out), .drv(a_drv)
);

// File: tb/tb_bus_xcvr.sv
module tb_bus_xcvr;
    localparam int W = 18;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    // index 0 = A-to-B, index 1 = B-to-A
    logic [W-1:0] din   [2];
    logic         pass  [2];
    logic         stb   [2];
    logic         sen_n [2];
    logic         drv_n [2];

    logic [W-1:0] a_out, b_out;
    logic         a_drv, b_drv;

    bus_xcvr #(.W(W)) dut (
        .clk(clk), .rst(rst),
        .a_in(din[0]), .a_out(a_out), .a_drv(a_drv),
        .b_in(din[1]), .b_out(b_out), .b_drv(b_drv),
        .ab_pass(pass[0]), .ab_strobe(stb[0]),
        .ab_strobe_en_n(sen_n[0]), .ab_drive_n(drv_n[0]),
        .ba_pass(pass[1]), .ba_strobe(stb[1]),
        .ba_strobe_en_n(sen_n[1]), .ba_drive_n(drv_n[1])
    );

    // Reference model built from the requirements
    logic [W-1:0] m_q    [2];
    logic         m_prev [2];
    always @(posedge clk) begin
        for (int d = 0; d < 2; d++) begin
            if (rst) begin
                m_q[d]    = '0;
                m_prev[d] = 1'b1;
            end else begin
                if (pass[d])
                    m_q[d] = din[d];
                else if (!sen_n[d] && stb[d] && !m_prev[d])
                    m_q[d] = din[d];
                m_prev[d] = stb[d];
            end
        end
    end

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    function automatic logic [W-1:0] out_of(int d);
        return (d == 0) ? b_out : a_out;
    endfunction

    function automatic logic drv_of(int d);
        return (d == 0) ? b_drv : a_drv;
    endfunction

    task automatic expect_val(string tag, int d, logic [W-1:0] got, logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s dir%0d: got %h expected %h", tag, d, got, exp);
        end
    endtask

    task automatic check_dir(string tag, int d);
        expect_val(tag, d, out_of(d), pass[d] ? din[d] : m_q[d]);
        expect_val(tag, d, {{(W-1){1'b0}}, drv_of(d)},
                   {{(W-1){1'b0}}, (!drv_n[d] && !rst)});
    endtask

    // One clock: edge, then observe both directions after the falling edge
    task automatic cyc(string tag);
        @(negedge clk);
        #1;
        check_dir(tag, 0);
        check_dir(tag, 1);
    endtask

    task automatic idle_all();
        for (int d = 0; d < 2; d++) begin
            din[d] = '0; pass[d] = 1'b0; stb[d] = 1'b0;
            sen_n[d] = 1'b1; drv_n[d] = 1'b1;
        end
    endtask

    task automatic t_reset();
        idle_all();
        rst = 1'b1;
        drv_n[0] = 1'b0; drv_n[1] = 1'b0;
        stb[0] = 1'b1; stb[1] = 1'b1;
        sen_n[0] = 1'b0; sen_n[1] = 1'b0;
        din[0] = 18'h2AAAA; din[1] = 18'h15555;
        cyc("R8");
        expect_val("R8 drv in reset", 0, {17'd0, b_drv}, '0);
        expect_val("R8 drv in reset", 1, {17'd0, a_drv}, '0);
        cyc("R8");
        rst = 1'b0;
        cyc("R8");
        // strobe stayed high across reset: no capture
        expect_val("R8 word after reset", 0, b_out, '0);
        expect_val("R8 word after reset", 1, a_out, '0);
        stb[0] = 1'b0; stb[1] = 1'b0;
        cyc("R8");
    endtask

    task automatic t_transparent(int d);
        pass[d] = 1'b1; drv_n[d] = 1'b0;
        for (int i = 0; i < 6; i++) begin
            din[d] = W'($urandom);
            stb[d] = i[0]; sen_n[d] = i[1];
            #1 expect_val("R1 same cycle", d, out_of(d), din[d]);
            cyc("R1");
        end
    endtask

    task automatic t_capture(int d);
        pass[d] = 1'b1; din[d] = 18'h00F0F; stb[d] = 1'b0; cyc("R2");
        pass[d] = 1'b0; cyc("R2");
        sen_n[d] = 1'b0; din[d] = 18'h3C3C3; cyc("R2");
        expect_val("R2 no edge yet", d, out_of(d), 18'h00F0F);
        stb[d] = 1'b1; cyc("R2");
        expect_val("R2 captured", d, out_of(d), 18'h3C3C3);
        din[d] = 18'h11111; cyc("R2");
        expect_val("R2 no recapture while high", d, out_of(d), 18'h3C3C3);
    endtask

    task automatic t_hold_low(int d);
        pass[d] = 1'b1; din[d] = 18'h0ABCD; stb[d] = 1'b0; sen_n[d] = 1'b0; cyc("R3");
        pass[d] = 1'b0;
        for (int i = 0; i < 4; i++) begin
            din[d] = W'($urandom);
            cyc("R3");
            expect_val("R3 hold low", d, out_of(d), 18'h0ABCD);
        end
    endtask

    task automatic t_hold_high(int d);
        stb[d] = 1'b1; pass[d] = 1'b1; sen_n[d] = 1'b0; din[d] = 18'h2468A; cyc("R4");
        pass[d] = 1'b0;
        for (int i = 0; i < 4; i++) begin
            din[d] = W'($urandom);
            cyc("R4");
            expect_val("R4 hold high", d, out_of(d), 18'h2468A);
        end
        stb[d] = 1'b0; cyc("R4");
    endtask

    task automatic t_gate(int d);
        pass[d] = 1'b1; din[d] = 18'h13579; stb[d] = 1'b0; cyc("R5");
        pass[d] = 1'b0; sen_n[d] = 1'b1;
        for (int i = 0; i < 6; i++) begin
            stb[d] = ~stb[d]; din[d] = W'($urandom);
            cyc("R5");
            expect_val("R5 edge ignored", d, out_of(d), 18'h13579);
        end
        stb[d] = 1'b0; cyc("R5");
    endtask

    task automatic t_late_edge(int d);
        stb[d] = 1'b0; pass[d] = 1'b1; sen_n[d] = 1'b0; din[d] = 18'h00001; cyc("R9");
        pass[d] = 1'b0; din[d] = 18'h3FFFE; cyc("R9");
        cyc("R9");
        stb[d] = 1'b1; cyc("R9");
        expect_val("R9 late edge", d, out_of(d), 18'h3FFFE);
        stb[d] = 1'b0; cyc("R9");
    endtask

    task automatic t_drive(int d);
        for (int i = 0; i < 4; i++) begin
            drv_n[d] = i[0]; pass[d] = i[1]; stb[d] = ~i[0];
            cyc("R6");
            expect_val("R6 drive flag", d, {17'd0, drv_of(d)}, {17'd0, ~i[0]});
        end
        stb[d] = 1'b0; cyc("R6");
    endtask

    task automatic t_store_off(int d);
        drv_n[d] = 1'b1; pass[d] = 1'b1; din[d] = 18'h0C0C0; cyc("R10");
        pass[d] = 1'b0; sen_n[d] = 1'b0; stb[d] = 1'b0; din[d] = 18'h30303; cyc("R10");
        stb[d] = 1'b1; cyc("R10");
        expect_val("R10 drive off", d, {17'd0, drv_of(d)}, '0);
        drv_n[d] = 1'b0; stb[d] = 1'b0; cyc("R10");
        expect_val("R10 updated while off", d, out_of(d), 18'h30303);
    endtask

    // Random sequences on direction d; the other direction is frozen
    task automatic t_random(int d);
        int o;
        logic [W-1:0] frozen;
        o = 1 - d;
        pass[o] = 1'b0; sen_n[o] = 1'b1; stb[o] = 1'b0; drv_n[o] = 1'b0;
        cyc("R7");
        frozen = out_of(o);
        for (int i = 0; i < 1500; i++) begin
            pass[d]  = ($urandom % 5) == 0;
            stb[d]   = $urandom;
            sen_n[d] = ($urandom % 3) == 0;
            drv_n[d] = $urandom;
            din[d]   = W'($urandom);
            din[o]   = W'($urandom);
            cyc("R7 random");
        end
        expect_val("R7 other lane untouched", o, out_of(o), frozen);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        errs++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        idle_all();
        t_reset();
        for (int d = 0; d < 2; d++) begin
            t_transparent(d);
            t_capture(d);
            t_hold_low(d);
            t_hold_high(d);
            t_gate(d);
            t_late_edge(d);
            t_drive(d);
            t_store_off(d);
        end
        t_random(0);
        t_random(1);
        finish_run();
    end
endmodule